// File: doc/BRIEF.md
# Multi-Frame Transmit Byte Queue

This block sits between a host that assembles outgoing frames byte by byte and a serial transmitter that sends them one frame at a time. The host pushes bytes into a circular byte store and closes each frame with a separate end-of-frame strobe. Several closed frames can wait in the store at once. Each one keeps its own boundary in a small table of end pointers, indexed by a 3-bit frame number.

The transmit side sees only the oldest closed frame. It requests bytes from that frame one at a time and is told when the frame has no bytes left. It then steps to the next queued frame, which also discards any bytes of the old frame that were never read. Status outputs tell the host when the byte store or the frame table is full. They also tell both sides whether any closed frame is waiting and whether the store holds nothing at all.

All pointers and counters clear on a synchronous reset, so the queue starts empty. The write-side and read-side frame numbers are then equal and both byte pointers are zero.

Top module: `txframe_fifo`

## Requirements
- R1: While `rst` is high on a clock edge, after that edge `empty`=1 and `frm_avail`, `frm_done`, `buf_full`, `q_full` and `rd_valid` are all 0.
- R2: Every accepted byte write stores `wr_data`. The bytes of a frame reach `rd_data` in the order they were written.
- R3: A cycle with `eof`=1 (when accepted) closes the open frame. The frame includes a byte written in that same cycle. `frm_avail` is 1 from the next cycle for as long as at least one closed frame is unsent.
- R4: `rd_req`=1 is a read when all of these hold: a frame is available, the frame still has unread bytes, and `next_frame` is 0. After a read, `rd_valid`=1 and `rd_data` holds the next byte in the following cycle. In every other cycle `rd_valid` is 0.
- R5: `frm_done` is 1 exactly when a frame is available and all of its bytes have been read (a zero-length frame is done at once). While it is 1, `rd_req` reads nothing and no byte is lost.
- R6: `next_frame`=1 while a frame is available moves to the next closed frame in the following cycle. Unread bytes of the current frame are dropped, and reading resumes at the first byte of the next frame.
- R7: With no closed frame, `rd_req` and `next_frame` have no effect: `rd_valid` stays 0 and the next frame closed later is read from its first byte.
- R8: `q_full`=1 when 7 closed frames are unsent. While it is 1, `eof` is ignored and the open frame keeps growing.
- R9: `buf_full`=1 when 511 bytes are held, counted from the first byte of the oldest unsent frame through the open frame. While it is 1, byte writes are ignored.
- R10: `empty`=1 exactly when there is no closed unsent frame and the open frame has no bytes.
- R11: Byte addresses wrap modulo 512. A frame stored across the end of the store reads back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| eof | input | 1 | Host end-of-frame strobe |
| rd_req | input | 1 | Transmitter request for the next byte |
| next_frame | input | 1 | Transmitter step to the next frame |
| rd_data | output | 8 | Byte returned one cycle after a read |
| rd_valid | output | 1 | `rd_data` holds a byte read in the previous cycle |
| frm_done | output | 1 | Current frame fully read |
| frm_avail | output | 1 | At least one closed frame is unsent |
| empty | output | 1 | No closed frames and no open bytes |
| buf_full | output | 1 | Byte store full, writes ignored |
| q_full | output | 1 | Frame table full, end-of-frame ignored |

## Verification
A corrupted frame number or end pointer shows up at the frame boundary. `frm_done` appears too early or too late, which is visible the cycle after the last byte should have been read, or `frm_avail` and `q_full` disagree with the number of closed frames right after an `eof` or `next_frame`. A wrong byte pointer shows on `rd_data` at the first affected read. It also shows on `buf_full` and `empty` as soon as the count of held bytes disagrees. Since every status output is compared against a behavioural queue model on every clock, a defect is reported within one cycle of the point where it first reaches a port.

// File: rtl/txframe_pkg.sv
package txframe_pkg;
   localparam int DEF_DW = 8;
   localparam int DEF_AW = 9;
   localparam int DEF_FW = 3;

   function automatic bit width_ok(input int w, input int lo, input int hi);
      return (w >= lo) && (w <= hi);
   endfunction
endpackage

// File: rtl/txframe_ram.sv
module txframe_ram #(
   parameter int DW = 8,
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/txframe_table.sv
module txframe_table #(
   parameter int AW = 9,
   parameter int FW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [FW-1:0] wslot,
   input  logic [AW-1:0] wend,
   input  logic [FW-1:0] rslot,
   output logic [AW-1:0] rend
);
   localparam int SLOTS = 1 << FW;

   logic [AW-1:0] end_q [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst)
            end_q[g] <= '0;
         else if (we && (wslot == FW'(g)))
            end_q[g] <= wend;
      end
   end

   assign rend = end_q[rslot];
endmodule

// File: rtl/txframe_ctrl.sv
module txframe_ctrl #(
   parameter int AW = 9,
   parameter int FW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic          eof,
   input  logic          rd_req,
   input  logic          next_frame,
   input  logic [AW-1:0] end_cur,
   output logic          ram_we,
   output logic [AW-1:0] ram_waddr,
   output logic          ram_re,
   output logic [AW-1:0] ram_raddr,
   output logic          tab_we,
   output logic [FW-1:0] tab_wslot,
   output logic [AW-1:0] tab_wend,
   output logic [FW-1:0] tab_rslot,
   output logic [FW-1:0] f1_o,
   output logic [FW-1:0] f2_o,
   output logic [AW-1:0] z1_o,
   output logic [AW-1:0] z2_o,
   output logic          buf_full,
   output logic          q_full,
   output logic          frm_avail,
   output logic          frm_done,
   output logic          empty,
   output logic          rd_valid
);
   logic [FW-1:0] f1_q, f2_q;
   logic [AW-1:0] z1_q, z2_q, base_q;
   logic [AW-1:0] z1_inc, z1_nxt;
   logic          wr_ok, eof_ok, nf_ok, rd_ok;

   assign z1_inc    = z1_q + 1'b1;
   assign buf_full  = (z1_inc == base_q);
   assign q_full    = (FW'(f1_q + 1'b1) == f2_q);
   assign frm_avail = (f1_q != f2_q);
   assign frm_done  = frm_avail && (z2_q == end_cur);
   assign empty     = !frm_avail && (z1_q == z2_q);

   assign wr_ok  = wr_en && !buf_full;
   assign eof_ok = eof && !q_full;
   assign nf_ok  = next_frame && frm_avail;
   assign rd_ok  = rd_req && frm_avail && !frm_done && !next_frame;
   assign z1_nxt = wr_ok ? z1_inc : z1_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         f1_q     <= '0;
         f2_q     <= '0;
         z1_q     <= '0;
         z2_q     <= '0;
         base_q   <= '0;
         rd_valid <= 1'b0;
      end else begin
         z1_q     <= z1_nxt;
         rd_valid <= rd_ok;
         if (eof_ok) f1_q <= f1_q + 1'b1;
         if (nf_ok) begin
            f2_q   <= f2_q + 1'b1;
            z2_q   <= end_cur;
            base_q <= end_cur;
         end else if (rd_ok) begin
            z2_q <= z2_q + 1'b1;
         end
      end
   end

   assign ram_we    = wr_ok;
   assign ram_waddr = z1_q;
   assign ram_re    = rd_ok;
   assign ram_raddr = z2_q;
   assign tab_we    = eof_ok;
   assign tab_wslot = f1_q;
   assign tab_wend  = z1_nxt;
   assign tab_rslot = f2_q;
   assign f1_o      = f1_q;
   assign f2_o      = f2_q;
   assign z1_o      = z1_q;
   assign z2_o      = z2_q;
endmodule

// File: rtl/txframe_fifo.sv
module txframe_fifo
   import txframe_pkg::*;
#(
   parameter int DW = DEF_DW,
   parameter int AW = DEF_AW,
   parameter int FW = DEF_FW
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          eof,
   input  logic          rd_req,
   input  logic          next_frame,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid,
   output logic          frm_done,
   output logic          frm_avail,
   output logic          empty,
   output logic          buf_full,
   output logic          q_full
);
   if (!width_ok(AW, 2, 16)) begin : g_bad_aw
      $error("txframe_fifo: AW out of range");
   end
   if (!width_ok(FW, 1, 6)) begin : g_bad_fw
      $error("txframe_fifo: FW out of range");
   end
   if (!width_ok(DW, 1, 64)) begin : g_bad_dw
      $error("txframe_fifo: DW out of range");
   end

   logic          ram_we, ram_re, tab_we;
   logic [AW-1:0] ram_waddr, ram_raddr, tab_wend, end_cur;
   logic [FW-1:0] tab_wslot, tab_rslot;
   logic [FW-1:0] f1_q, f2_q;
   logic [AW-1:0] z1_q, z2_q;

   txframe_ctrl #(.AW(AW), .FW(FW)) ctrl_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .eof(eof), .rd_req(rd_req),
      .next_frame(next_frame), .end_cur(end_cur),
      .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_re(ram_re), .ram_raddr(ram_raddr),
      .tab_we(tab_we), .tab_wslot(tab_wslot), .tab_wend(tab_wend), .tab_rslot(tab_rslot),
      .f1_o(f1_q), .f2_o(f2_q), .z1_o(z1_q), .z2_o(z2_q),
      .buf_full(buf_full), .q_full(q_full), .frm_avail(frm_avail),
      .frm_done(frm_done), .empty(empty), .rd_valid(rd_valid)
   );

   txframe_table #(.AW(AW), .FW(FW)) table_i (
      .clk(clk), .rst(rst), .we(tab_we), .wslot(tab_wslot), .wend(tab_wend),
      .rslot(tab_rslot), .rend(end_cur)
   );

   txframe_ram #(.DW(DW), .AW(AW)) ram_i (
      .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(wr_data),
      .re(ram_re), .raddr(ram_raddr), .rdata(rd_data)
   );
endmodule

// File: rtl/txframe_fifo_chk.sv
module txframe_fifo_chk #(
   parameter int AW = 9,
   parameter int FW = 3
) (
   input logic          clk,
   input logic          rst,
   input logic          wr_en,
   input logic          eof,
   input logic          rd_req,
   input logic          next_frame,
   input logic          rd_valid,
   input logic          frm_done,
   input logic          frm_avail,
   input logic          empty,
   input logic          buf_full,
   input logic          q_full,
   input logic [FW-1:0] f1,
   input logic [FW-1:0] f2,
   input logic [AW-1:0] z1,
   input logic [AW-1:0] z2,
   input logic [AW-1:0] end_cur
);
   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (empty && !frm_avail && !frm_done && !buf_full && !q_full && !rd_valid));

   // R9
   wr_block_chk: assert property (@(posedge clk) disable iff (rst)
      (buf_full && wr_en) |=> $stable(z1));

   // R8
   eof_block_chk: assert property (@(posedge clk) disable iff (rst)
      (q_full && eof) |=> $stable(f1));

   // R7
   idle_rd_chk: assert property (@(posedge clk) disable iff (rst)
      (!frm_avail && rd_req) |=> !rd_valid);

   // R7
   idle_nf_chk: assert property (@(posedge clk) disable iff (rst)
      !frm_avail |=> $stable(f2));

   // R5
   done_rd_chk: assert property (@(posedge clk) disable iff (rst)
      (frm_done && rd_req && !next_frame) |=> (!rd_valid && $stable(z2)));

   // R6
   skip_chk: assert property (@(posedge clk) disable iff (rst)
      (next_frame && frm_avail) |=> (z2 == $past(end_cur) && f2 != $past(f2)));
endmodule

bind txframe_fifo txframe_fifo_chk #(.AW(AW), .FW(FW)) chk_i (
   .clk(clk), .rst(rst), .wr_en(wr_en), .eof(eof), .rd_req(rd_req),
   .next_frame(next_frame), .rd_valid(rd_valid), .frm_done(frm_done),
   .frm_avail(frm_avail), .empty(empty), .buf_full(buf_full), .q_full(q_full),
   .f1(f1_q), .f2(f2_q), .z1(z1_q), .z2(z2_q), .end_cur(end_cur)
);

// File: tb/txframe_fifo_tb.sv
module txframe_fifo_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0, eof = 1'b0, rd_req = 1'b0, next_frame = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       rd_valid, frm_done, frm_avail, empty, buf_full, q_full;

   int    checks = 0;
   int    errors = 0;
   string phase = "R1";
   bit    armed = 1'b0;

   // behavioural model: bytes from the oldest unsent frame onwards
   logic [7:0] mbytes[$];
   int         flen[$];
   int         open_len = 0;
   int         rd_idx = 0;
   logic       m_valid = 1'b0;
   logic [7:0] m_data = '0;

   always #5 clk = ~clk;

   txframe_fifo dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .eof(eof),
      .rd_req(rd_req), .next_frame(next_frame), .rd_data(rd_data),
      .rd_valid(rd_valid), .frm_done(frm_done), .frm_avail(frm_avail),
      .empty(empty), .buf_full(buf_full), .q_full(q_full)
   );

   function automatic int occ();
      int s = open_len;
      foreach (flen[i]) s += flen[i];
      return s;
   endfunction

   function automatic bit m_done();
      return (flen.size() > 0) && (rd_idx == flen[0]);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s (phase %s): actual %0d expected %0d", tag, phase, act, exp);
      end
   endtask

   always @(posedge clk) begin
      bit avail, done, wr_ok, eof_ok, nf_ok, rd_ok;
      if (rst) begin
         mbytes.delete(); flen.delete();
         open_len = 0; rd_idx = 0; m_valid = 1'b0;
      end else begin
         avail  = flen.size() > 0;
         done   = m_done();
         wr_ok  = wr_en && (occ() != 511);
         eof_ok = eof && (flen.size() != 7);
         nf_ok  = next_frame && avail;
         rd_ok  = rd_req && avail && !done && !next_frame;
         m_valid = rd_ok;
         if (rd_ok) begin
            m_data = mbytes[rd_idx];
            rd_idx++;
         end
         if (wr_ok) begin
            mbytes.push_back(wr_data);
            open_len++;
         end
         if (eof_ok) begin
            flen.push_back(open_len);
            open_len = 0;
         end
         if (nf_ok) begin
            repeat (flen[0]) void'(mbytes.pop_front());
            void'(flen.pop_front());
            rd_idx = 0;
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (armed && !rst) begin
         chk(empty == (flen.size() == 0 && open_len == 0), "R10", empty, flen.size() == 0 && open_len == 0);
         chk(frm_avail == (flen.size() > 0), "R3", frm_avail, flen.size() > 0);
         chk(frm_done == m_done(), "R5", frm_done, m_done());
         chk(q_full == (flen.size() == 7), "R8", q_full, flen.size() == 7);
         chk(buf_full == (occ() == 511), "R9", buf_full, occ() == 511);
         chk(rd_valid == m_valid, "R4", rd_valid, m_valid);
         if (m_valid) chk(rd_data === m_data, "R2", rd_data, m_data);
      end
   end

   task automatic cyc(input bit w, input logic [7:0] d, input bit e, input bit r, input bit n);
      @(negedge clk);
      wr_en = w; wr_data = d; eof = e; rd_req = r; next_frame = n;
   endtask

   task automatic idle();
      cyc(0, 8'h00, 0, 0, 0);
   endtask

   task automatic drain();
      while (flen.size() > 0) begin
         if (m_done()) cyc(0, 8'h00, 0, 0, 1);
         else          cyc(0, 8'h00, 0, 1, 0);
      end
      idle(); idle();
   endtask

   initial begin
      fork
         begin : main
            repeat (3) @(negedge clk);
            rst = 1'b0;
            armed = 1'b1;
            // R1: state right after reset
            chk(empty && !frm_avail && !frm_done && !buf_full && !q_full && !rd_valid,
                "R1", {empty, frm_avail, frm_done, buf_full, q_full, rd_valid}, 6'b100000);

            // R2 / R3: two frames, second closed together with its last byte
            phase = "R3";
            for (int i = 0; i < 3; i++) cyc(1, 8'h11 + 8'(i), 0, 0, 0);
            cyc(0, 8'h00, 1, 0, 0);
            for (int i = 0; i < 5; i++) cyc(1, 8'h40 + 8'(i), (i == 4), 0, 0);
            idle();

            // R4 / R5: read the first frame and keep requesting after it ends
            phase = "R5";
            repeat (5) cyc(0, 8'h00, 0, 1, 0);
            idle();

            // R6: advance, read two bytes, skip the rest
            phase = "R6";
            cyc(0, 8'h00, 0, 0, 1);
            repeat (2) cyc(0, 8'h00, 0, 1, 0);
            cyc(0, 8'h00, 0, 1, 1);
            idle();

            // R7: no frame queued
            phase = "R7";
            repeat (2) cyc(0, 8'h00, 0, 1, 0);
            cyc(0, 8'h00, 0, 0, 1);
            cyc(1, 8'h77, 1, 0, 0);
            repeat (2) cyc(0, 8'h00, 0, 1, 0);
            drain();

            // R8: fill the frame table, eighth close ignored
            phase = "R8";
            for (int i = 0; i < 8; i++) cyc(1, 8'h80 + 8'(i), 1, 0, 0);
            cyc(1, 8'h90, 0, 0, 0);
            idle();
            drain();
            cyc(0, 8'h00, 1, 0, 0);
            drain();

            // R9: fill the byte store
            phase = "R9";
            for (int i = 0; i < 515; i++) cyc(1, 8'(i * 7), 0, 0, 0);
            cyc(0, 8'h00, 1, 0, 0);
            drain();

            // R11: frames that cross the end of the store, written while reading
            phase = "R11";
            for (int k = 0; k < 4; k++) begin
               for (int i = 0; i < 300; i++) cyc(1, 8'(i + 13 * k), (i == 299), 0, 0);
               for (int i = 0; i < 150; i++) cyc(1, 8'(i ^ k), 0, !m_done(), 0);
               cyc(0, 8'h00, 1, 0, 0);
               drain();
            end
            idle();
         end
         begin : watchdog
            repeat (50000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule